// File: doc/BRIEF.md
# Firmware Download Session Sequencer

This block follows a field firmware download inside a storage device controller. The host moves the device between a normal mode and a download mode by writing a one-byte mode-configuration value. It also declares the size of the new firmware image in bytes. It then issues write-block commands, and each of these carries a command argument and a block length. The flash back end pulses a sector-done strobe each time one sector of the image has been programmed correctly. The block checks each write against the download rules and keeps a count of correctly programmed sectors. It reports when the whole declared image is present.

The sector count is kept when the host leaves download mode and comes back, so an interrupted download resumes from the next sector. A count of zero tells the host to start again from the first sector. A command-level reset or a hardware reset that arrives before the image is complete aborts the session and clears the count. A reset that arrives in normal mode with a complete image starts installation, which is shown as a one-cycle pulse. Rule violations appear as one-cycle error pulses. These cover a wrong argument, a wrong block length, a size that is not sector-aligned, and a sector beyond the declared image.

Top module: `fwdl_seq`

## Requirements
- R1: After the synchronous reset `rst`, the block is in normal mode (`dl_mode`=0), `sect_cnt`=0, `img_sects`=0, and `install_ready`, `install_go` and all four error outputs are 0.
- R2: A mode write (`cfg_we`) with `cfg_val`=0x00 selects normal mode and 0x01 selects download mode, visible on `dl_mode` one cycle later. Any other value leaves the mode unchanged.
- R3: In download mode, a write command whose `wr_arg` differs from `DL_ARG` raises `err_arg` for exactly the next cycle. It also closes the write, so later `sect_done` pulses are not counted until a legal write is accepted.
- R4: In download mode, a write command whose `wr_blen` differs from `SECT_BYTES` (512 by default) raises `err_len` for the next cycle and closes the write.
- R5: A size declaration (`decl_valid`) whose `decl_bytes` is not a multiple of `SECT_BYTES` raises `err_align` and leaves `img_sects` unchanged. An aligned declaration sets `img_sects` to `decl_bytes`/`SECT_BYTES` and clears `sect_cnt`.
- R6: `sect_done` raises `sect_cnt` by one only in download mode after a legal write has been accepted. Entering download mode does not by itself open a write.
- R7: Outside download mode, write commands and `sect_done` pulses leave `sect_cnt` unchanged and raise no error.
- R8: A `sect_done` that is counted would otherwise take `sect_cnt` past `img_sects`. Instead, the block raises `err_over` and keeps `sect_cnt` unchanged.
- R9: With `ABORT_ON_EXIT`=0 (the default), leaving download mode keeps `sect_cnt`. After download mode is entered again and a legal write is accepted, counting continues from the kept value.
- R10: A `cmd0_evt` or `hwrst_evt` pulse while the image is incomplete clears `sect_cnt` to 0 and returns the block to normal mode.
- R11: `install_ready` is 1 exactly when `img_sects` is nonzero and `sect_cnt` equals `img_sects`.
- R12: A `cmd0_evt` or `hwrst_evt` pulse in normal mode with `install_ready`=1 gives a single-cycle `install_go` pulse and clears `sect_cnt` and `img_sects`. The same pulse in download mode only returns to normal mode, keeps the count and gives no `install_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| cfg_we | input | 1 | Mode-configuration write strobe |
| cfg_val | input | 8 | Mode value: 0x00 normal, 0x01 download |
| wr_valid | input | 1 | Write-block command strobe |
| wr_arg | input | ARG_W (32) | Write command argument |
| wr_blen | input | BLEN_W (16) | Current block length in bytes |
| decl_valid | input | 1 | Image size declaration strobe |
| decl_bytes | input | CNT_W+log2(SECT_BYTES) (17) | Declared image size in bytes |
| sect_done | input | 1 | One sector programmed correctly |
| cmd0_evt | input | 1 | Command-level reset event |
| hwrst_evt | input | 1 | Hardware reset pin event |
| dl_mode | output | 1 | 1 while in download mode |
| sect_cnt | output | CNT_W (8) | Sectors programmed correctly |
| img_sects | output | CNT_W (8) | Declared image size in sectors |
| install_ready | output | 1 | Whole declared image present |
| install_go | output | 1 | One-cycle pulse: install the new image |
| err_arg | output | 1 | Pulse: wrong argument in download mode |
| err_len | output | 1 | Pulse: wrong block length in download mode |
| err_align | output | 1 | Pulse: declared size not sector-aligned |
| err_over | output | 1 | Pulse: sector beyond declared image |

## Verification
The bench sweeps every mode value from 0x00 to 0xFF. This separates the two accepted codes from values that must be ignored. It declares image sizes of one to six sectors and writes each one through to completion, checking the count and `install_ready` after every sector, an overrun pulse past the end, and installation on reset. This shows that each size ends exactly at its own count. Sizes that miss alignment by a spread of byte offsets separate aligned declarations from misaligned ones. Further sequences tell apart a resumed session and an aborted one. They also distinguish a reset that installs from a reset in download mode that does not, and a legal write from one rejected for its argument or its block length.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_DL     = 1'b1
    } mode_e;

    localparam logic [7:0] CFG_NORMAL = 8'h00;
    localparam logic [7:0] CFG_DL     = 8'h01;

    typedef struct packed {
        logic arg_bad;
        logic len_bad;
    } wr_chk_t;

    function automatic logic cfg_is_known(input logic [7:0] v);
        return (v == CFG_NORMAL) || (v == CFG_DL);
    endfunction

endpackage

// File: rtl/fwdl_cmd_check.sv
module fwdl_cmd_check
    import fwdl_pkg::*;
#(
    parameter int ARG_W = 32,
    parameter int BLEN_W = 16,
    parameter logic [ARG_W-1:0] DL_ARG = 32'hF0A5_0001,
    parameter int SECT_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ARG_W-1:0]  wr_arg,
    input  logic [BLEN_W-1:0] wr_blen,
    input  mode_e             mode,
    output logic              wr_ok,
    output logic              wr_bad,
    output logic              err_arg,
    output logic              err_len
);
    localparam logic [BLEN_W-1:0] BLEN_OK = BLEN_W'(SECT_BYTES);

    wr_chk_t chk;
    logic    in_dl;

    always_comb begin
        chk.arg_bad = (wr_arg != DL_ARG);
        chk.len_bad = (wr_blen != BLEN_OK);
        in_dl  = wr_valid && (mode == MODE_DL);
        wr_ok  = in_dl && !chk.arg_bad && !chk.len_bad;
        wr_bad = in_dl && (chk.arg_bad || chk.len_bad);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_arg <= 1'b0;
            err_len <= 1'b0;
        end else begin
            err_arg <= in_dl && chk.arg_bad;
            err_len <= in_dl && chk.len_bad;
        end
    end

    assert_err_only_dl_R7: assert property (@(posedge clk) disable iff (rst)
        (err_arg || err_len) |-> $past(mode) == MODE_DL);
    assert_err_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (err_arg && !$past(wr_valid, 1)) |-> 1'b0);

endmodule

// File: rtl/fwdl_mode_ctl.sv
module fwdl_mode_ctl
    import fwdl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_val,
    input  logic       rst_evt,
    input  logic       wr_ok,
    input  logic       wr_bad,
    output mode_e      mode,
    output logic       wr_open,
    output logic       leave_dl
);
    logic cfg_hit;

    always_comb begin
        cfg_hit  = cfg_we && cfg_is_known(cfg_val);
        leave_dl = cfg_hit && (cfg_val == CFG_NORMAL) && (mode == MODE_DL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MODE_NORMAL;
            wr_open <= 1'b0;
        end else if (rst_evt) begin
            mode    <= MODE_NORMAL;
            wr_open <= 1'b0;
        end else if (cfg_hit) begin
            mode    <= (cfg_val == CFG_DL) ? MODE_DL : MODE_NORMAL;
            wr_open <= 1'b0;
        end else if (wr_ok) begin
            wr_open <= 1'b1;
        end else if (wr_bad) begin
            wr_open <= 1'b0;
        end
    end

    assert_open_needs_dl_R6: assert property (@(posedge clk) disable iff (rst)
        wr_open |-> mode == MODE_DL);
    assert_unknown_cfg_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_is_known(cfg_val) && !rst_evt) |=> $stable(mode));

endmodule

// File: rtl/fwdl_sector_ctr.sv
module fwdl_sector_ctr
    import fwdl_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SECT_BYTES = 512,
    parameter bit ABORT_ON_EXIT = 1'b0,
    localparam int SECT_LG = $clog2(SECT_BYTES),
    localparam int DB_W = CNT_W + SECT_LG
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic             rst_evt,
    input  logic             leave_dl,
    input  logic             decl_valid,
    input  logic [DB_W-1:0]  decl_bytes,
    input  logic             inc_req,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] tgt,
    output logic             ready,
    output logic             install_go,
    output logic             err_align,
    output logic             err_over
);
    logic aligned;
    logic exit_clear;

    generate
        if (ABORT_ON_EXIT) begin : g_abort_exit
            assign exit_clear = leave_dl;
        end else begin : g_keep_exit
            assign exit_clear = 1'b0;
        end
    endgenerate

    always_comb begin
        aligned = (decl_bytes[SECT_LG-1:0] == '0);
        ready   = (tgt != '0) && (cnt == tgt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            tgt        <= '0;
            install_go <= 1'b0;
            err_align  <= 1'b0;
            err_over   <= 1'b0;
        end else begin
            install_go <= 1'b0;
            err_align  <= 1'b0;
            err_over   <= 1'b0;
            if (rst_evt) begin
                if (ready && mode == MODE_NORMAL) begin
                    install_go <= 1'b1;
                    cnt        <= '0;
                    tgt        <= '0;
                end else if (!ready) begin
                    cnt <= '0;
                end
            end else if (decl_valid) begin
                if (aligned) begin
                    tgt <= decl_bytes[DB_W-1:SECT_LG];
                    cnt <= '0;
                end else begin
                    err_align <= 1'b1;
                end
            end else if (exit_clear && !ready) begin
                cnt <= '0;
            end else if (inc_req) begin
                if (cnt < tgt) cnt <= cnt + 1'b1;
                else           err_over <= 1'b1;
            end
        end
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= tgt);
    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1) || (cnt == '0));
    assert_go_src_R12: assert property (@(posedge clk) disable iff (rst)
        install_go |-> $past(ready) && $past(mode) == MODE_NORMAL);
    assert_go_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        install_go |=> !install_go);

endmodule

// File: rtl/fwdl_seq.sv
module fwdl_seq
    import fwdl_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SECT_BYTES = 512,
    parameter int ARG_W = 32,
    parameter int BLEN_W = 16,
    parameter logic [ARG_W-1:0] DL_ARG = 32'hF0A5_0001,
    parameter bit ABORT_ON_EXIT = 1'b0,
    localparam int DB_W = CNT_W + $clog2(SECT_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_val,
    input  logic              wr_valid,
    input  logic [ARG_W-1:0]  wr_arg,
    input  logic [BLEN_W-1:0] wr_blen,
    input  logic              decl_valid,
    input  logic [DB_W-1:0]   decl_bytes,
    input  logic              sect_done,
    input  logic              cmd0_evt,
    input  logic              hwrst_evt,
    output logic              dl_mode,
    output logic [CNT_W-1:0]  sect_cnt,
    output logic [CNT_W-1:0]  img_sects,
    output logic              install_ready,
    output logic              install_go,
    output logic              err_arg,
    output logic              err_len,
    output logic              err_align,
    output logic              err_over
);
    mode_e mode;
    logic  rst_evt, wr_ok, wr_bad, wr_open, leave_dl, inc_req;

    assign rst_evt = cmd0_evt || hwrst_evt;
    assign inc_req = sect_done && wr_open && (mode == MODE_DL);
    assign dl_mode = (mode == MODE_DL);

    fwdl_cmd_check #(
        .ARG_W(ARG_W), .BLEN_W(BLEN_W), .DL_ARG(DL_ARG), .SECT_BYTES(SECT_BYTES)
    ) u_chk (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_arg(wr_arg),
        .wr_blen(wr_blen), .mode(mode), .wr_ok(wr_ok), .wr_bad(wr_bad),
        .err_arg(err_arg), .err_len(err_len)
    );

    fwdl_mode_ctl u_mode (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_val(cfg_val),
        .rst_evt(rst_evt), .wr_ok(wr_ok), .wr_bad(wr_bad), .mode(mode),
        .wr_open(wr_open), .leave_dl(leave_dl)
    );

    fwdl_sector_ctr #(
        .CNT_W(CNT_W), .SECT_BYTES(SECT_BYTES), .ABORT_ON_EXIT(ABORT_ON_EXIT)
    ) u_ctr (
        .clk(clk), .rst(rst), .mode(mode), .rst_evt(rst_evt),
        .leave_dl(leave_dl), .decl_valid(decl_valid), .decl_bytes(decl_bytes),
        .inc_req(inc_req), .cnt(sect_cnt), .tgt(img_sects),
        .ready(install_ready), .install_go(install_go),
        .err_align(err_align), .err_over(err_over)
    );

    assert_evt_abort_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(rst_evt) && !$past(install_ready)) |-> sect_cnt == '0 && !dl_mode);
    assert_outside_dl_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MODE_NORMAL && !$past(rst_evt) && !$past(decl_valid))
            |-> $stable(sect_cnt));

endmodule

// File: tb/fwdl_seq_tb_top.sv
module fwdl_seq_tb_top;
    localparam int CLK_P = 10;
    localparam int CNT_W = 8;
    localparam int SB = 512;
    localparam int DB_W = CNT_W + 9;
    localparam logic [31:0] ARG = 32'hF0A5_0001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, wr_valid = 0, decl_valid = 0, sect_done = 0, cmd0_evt = 0, hwrst_evt = 0;
    logic [7:0] cfg_val = 0;
    logic [31:0] wr_arg = 0;
    logic [15:0] wr_blen = 0;
    logic [DB_W-1:0] decl_bytes = 0;
    logic dl_mode, install_ready, install_go, err_arg, err_len, err_align, err_over;
    logic [CNT_W-1:0] sect_cnt, img_sects;
    int checks = 0, fails = 0;

    always #(CLK_P/2) clk = ~clk;

    fwdl_seq dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_val(cfg_val),
        .wr_valid(wr_valid), .wr_arg(wr_arg), .wr_blen(wr_blen),
        .decl_valid(decl_valid), .decl_bytes(decl_bytes), .sect_done(sect_done),
        .cmd0_evt(cmd0_evt), .hwrst_evt(hwrst_evt), .dl_mode(dl_mode),
        .sect_cnt(sect_cnt), .img_sects(img_sects), .install_ready(install_ready),
        .install_go(install_go), .err_arg(err_arg), .err_len(err_len),
        .err_align(err_align), .err_over(err_over)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        cfg_we = 0; wr_valid = 0; decl_valid = 0; sect_done = 0;
        cmd0_evt = 0; hwrst_evt = 0;
    endtask

    task automatic cfg(input logic [7:0] v);  cfg_we = 1; cfg_val = v; tick(); endtask
    task automatic wr(input logic [31:0] a, input logic [15:0] b);
        wr_valid = 1; wr_arg = a; wr_blen = b; tick();
    endtask
    task automatic decl(input int bytes); decl_valid = 1; decl_bytes = DB_W'(bytes); tick(); endtask
    task automatic sd();   sect_done = 1; tick(); endtask
    task automatic c0();   cmd0_evt = 1; tick(); endtask
    task automatic hw();   hwrst_evt = 1; tick(); endtask

    initial begin
        #(CLK_P * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 mode", dl_mode, 0); chk("R1 cnt", sect_cnt, 0); chk("R1 img", img_sects, 0);
        chk("R1 ready", install_ready, 0); chk("R1 go", install_go, 0);
        chk("R1 errs", {err_arg, err_len, err_align, err_over}, 0);

        // R2 mode value sweep
        cfg(8'h01); chk("R2 dl", dl_mode, 1);
        for (int v = 2; v < 256; v++) begin
            cfg(8'(v)); chk("R2 ignored in dl", dl_mode, 1);
        end
        cfg(8'h00); chk("R2 normal", dl_mode, 0);
        for (int v = 2; v < 256; v += 17) begin
            cfg(8'(v)); chk("R2 ignored in normal", dl_mode, 0);
        end

        // R7 outside download mode
        decl(3 * SB); chk("R5 img", img_sects, 3);
        wr(ARG, 16'(SB)); sd(); chk("R7 cnt", sect_cnt, 0);
        wr(ARG ^ 32'h1, 16'd8); chk("R7 no err", err_arg + err_len, 0);
        sd(); chk("R7 cnt2", sect_cnt, 0); chk("R7 over", err_over, 0);

        // R5 alignment sweep
        for (int off = 1; off < SB; off += 37) begin
            decl(2 * SB + off);
            chk("R5 misaligned err", err_align, 1); chk("R5 img kept", img_sects, 3);
        end
        tick(); chk("R5 err pulse", err_align, 0);

        // R6 R8 R11 R12 size sweep
        for (int n = 1; n <= 6; n++) begin
            decl(n * SB); chk("R5 img n", img_sects, n); chk("R5 cnt clr", sect_cnt, 0);
            cfg(8'h01); wr(ARG, 16'(SB));
            for (int k = 1; k <= n; k++) begin
                sd(); chk("R6 count", sect_cnt, k); chk("R11 ready", install_ready, int'(k == n));
            end
            sd(); chk("R8 over", err_over, 1); chk("R8 cnt held", sect_cnt, n);
            cfg(8'h00); chk("R9 kept on exit", sect_cnt, n);
            c0(); chk("R12 go", install_go, 1);
            tick(); chk("R12 go pulse", install_go, 0);
            chk("R12 cnt clr", sect_cnt, 0); chk("R12 img clr", img_sects, 0);
        end

        // R3 R4 R6
        decl(4 * SB); cfg(8'h01);
        sd(); chk("R6 no write open", sect_cnt, 0);
        wr(ARG ^ 32'h100, 16'(SB)); chk("R3 err_arg", err_arg, 1); chk("R3 len ok", err_len, 0);
        tick(); chk("R3 pulse", err_arg, 0);
        wr(ARG, 16'(SB)); wr(ARG ^ 32'h1, 16'(SB)); sd(); chk("R3 write closed", sect_cnt, 0);
        wr(ARG, 16'd256); chk("R4 err_len", err_len, 1); chk("R4 arg ok", err_arg, 0);
        sd(); chk("R4 write closed", sect_cnt, 0);

        // R9 resume
        wr(ARG, 16'(SB)); sd(); sd(); chk("R9 cnt", sect_cnt, 2);
        cfg(8'h00); chk("R9 mode", dl_mode, 0); chk("R9 kept", sect_cnt, 2);
        cfg(8'h01); wr(ARG, 16'(SB)); sd(); chk("R9 resume", sect_cnt, 3);

        // R10 abort
        hw(); chk("R10 hw cnt", sect_cnt, 0); chk("R10 hw mode", dl_mode, 0);
        chk("R10 no go", install_go, 0);
        cfg(8'h01); wr(ARG, 16'(SB)); sd(); chk("R6 after abort", sect_cnt, 1);
        c0(); chk("R10 cmd0 cnt", sect_cnt, 0); chk("R10 cmd0 mode", dl_mode, 0);

        // R12 reset in download mode with full image
        decl(2 * SB); cfg(8'h01); wr(ARG, 16'(SB)); sd(); sd();
        hw(); chk("R12 dl mode left", dl_mode, 0); chk("R12 dl no go", install_go, 0);
        chk("R12 dl cnt kept", sect_cnt, 2);
        c0(); chk("R12 go after normal", install_go, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule